// File: doc/BRIEF.md
# Double-Talk Detector With Programmable Threshold

This block decides, one sample at a time, whether the near-end talker is active while far-end speech is also present. It follows two signed 16-bit linear PCM streams: the far-end reference that drives the echo path, and the near-end send input that carries the echo and any local speech. For each stream it keeps a peak-hold magnitude estimate. The estimate jumps up to a larger sample magnitude at once and otherwise decays slowly. When the near-end estimate exceeds a programmable fraction of the far-end estimate, the block raises a double-talk flag. An echo canceller uses that flag to stop adapting its filter.

The fraction is a 16-bit unsigned Q15 threshold. It is written through a simple register write port and comes out of reset at 0x4800 (0.5625, about -5 dB). A purely echoic path with at least 6 dB of return loss gives a ratio of 0.5 or less, so this default leaves a margin above that. Software can rewrite the threshold at any time to match paths with more or less return loss. Once the flag is raised, it is held for a hangover of a set number of samples after the condition last held, so that it does not drop out between syllables. Both level estimates are also brought out so that the surrounding logic can observe them.

Top module: `dtd_detector`

## Requirements
- R1: After reset the double-talk flag is 0, both level outputs are 0, and the threshold is 0x4800.
- R2: On a cycle with the sample strobe high, if a stream's sample magnitude (two's complement absolute value, where -32768 gives 32768) exceeds that stream's level, the level becomes that magnitude.
- R3: On a strobe whose sample magnitude does not exceed the level, the level becomes level - (level >> 6). For example, 1000 becomes 985, and any level below 64 stays unchanged.
- R4: On cycles with the strobe low, neither the levels nor the flag change, whatever the sample inputs carry.
- R5: At a strobe, double talk holds when the updated near level is strictly greater than (updated far level × threshold) >> 15. Equality does not count. The flag is set in the same clock edge, so it is visible one cycle later.
- R6: When the updated far level is 0, any nonzero updated near level counts as double talk.
- R7: A write stores wdata as the Q15 threshold. The new value is used from the next strobe after the write edge. A write in the same cycle as a strobe does not affect that strobe.
- R8: After the last strobe at which double talk held, the flag stays 1 for the next 240 strobes without the condition and drops to 0 at the 241st.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| thr_we | input | 1 | Threshold write enable |
| thr_wdata | input | 16 | Q15 threshold value to write |
| smp_valid | input | 1 | Sample strobe, one cycle per sample pair |
| far_smp | input | 16 | Far-end reference sample, signed |
| near_smp | input | 16 | Near-end send sample, signed |
| far_lvl | output | 16 | Far-end peak-hold level |
| near_lvl | output | 16 | Near-end peak-hold level |
| dt_flag | output | 1 | Double-talk flag with hangover |

## Verification
The bench builds the block with its default parameters: 16-bit samples and threshold, a decay shift of 6, a hangover of 240 samples and a reset threshold of 0x4800. With these values the exact boundary products can be computed by hand. At the default threshold a far level of 10000 gives exactly 5625, and at 0x2000 it gives exactly 2500, so both the equality case and the one-above case are reachable. The full 240-strobe hangover fits easily in a short run. The levels of 63 (below the decay step) and 32768 (from -32768) exercise the edges of the tracker arithmetic.

// File: rtl/dtd_pkg.sv
package dtd_pkg;
    localparam int Q_FRAC = 15;
    localparam int NUM_STREAMS = 2;

    typedef enum int {
        STREAM_FAR  = 0,
        STREAM_NEAR = 1
    } stream_e;
endpackage

// File: rtl/dtd_level_track.sv
module dtd_level_track #(
    parameter int W        = 16,
    parameter int DECAY_SH = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         smp_valid,
    input  logic [W-1:0] smp,
    output logic [W-1:0] lvl_next,
    output logic [W-1:0] lvl
);
    typedef struct packed {
        logic [W-1:0] lvl;
    } state_t;

    state_t       st_d, st_q;
    logic [W-1:0] mag;

    always_comb begin
        // two's complement magnitude; the most negative code maps to 2^(W-1)
        mag  = smp[W-1] ? (~smp + 1'b1) : smp;
        st_d = st_q;
        if (smp_valid) begin
            if (mag > st_q.lvl) begin
                st_d.lvl = mag;
            end else begin
                st_d.lvl = st_q.lvl - (st_q.lvl >> DECAY_SH);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign lvl_next = st_d.lvl;
    assign lvl      = st_q.lvl;
endmodule

// File: rtl/dtd_ratio_cmp.sv
module dtd_ratio_cmp #(
    parameter int W  = 16,
    parameter int TW = 16
) (
    input  logic [W-1:0]  far_lvl,
    input  logic [W-1:0]  near_lvl,
    input  logic [TW-1:0] thr,
    output logic          hit
);
    import dtd_pkg::*;

    localparam int PW = W + TW;

    logic [PW-1:0] prod;
    logic [PW-1:0] scaled;
    logic [PW-1:0] near_ext;

    always_comb begin
        prod     = PW'(far_lvl) * PW'(thr);
        scaled   = prod >> Q_FRAC;
        near_ext = PW'(near_lvl);
        if (far_lvl == '0) begin
            hit = (near_lvl != '0);
        end else begin
            hit = (near_ext > scaled);
        end
    end
endmodule

// File: rtl/dtd_hangover.sv
module dtd_hangover #(
    parameter int HANG = 240
) (
    input  logic clk,
    input  logic rst_n,
    input  logic smp_valid,
    input  logic hit,
    output logic flag
);
    localparam int CW = $clog2(HANG + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          flag;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (smp_valid) begin
            if (hit) begin
                st_d.cnt  = CW'(HANG);
                st_d.flag = 1'b1;
            end else if (st_q.cnt != '0) begin
                st_d.cnt  = st_q.cnt - 1'b1;
            end else begin
                st_d.flag = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag = st_q.flag;
endmodule

// File: rtl/dtd_detector.sv
module dtd_detector #(
    parameter int          SMP_W     = 16,
    parameter int          THR_W     = 16,
    parameter int          DECAY_SH  = 6,
    parameter int          HANG      = 240,
    parameter logic [15:0] THR_RESET = 16'h4800
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             thr_we,
    input  logic [THR_W-1:0] thr_wdata,
    input  logic             smp_valid,
    input  logic [SMP_W-1:0] far_smp,
    input  logic [SMP_W-1:0] near_smp,
    output logic [SMP_W-1:0] far_lvl,
    output logic [SMP_W-1:0] near_lvl,
    output logic             dt_flag
);
    import dtd_pkg::*;

    typedef struct packed {
        logic [THR_W-1:0] thr;
    } state_t;

    state_t st_d, st_q;

    logic [SMP_W-1:0] smp_arr  [NUM_STREAMS];
    logic [SMP_W-1:0] lvl_nx   [NUM_STREAMS];
    logic [SMP_W-1:0] lvl_cur  [NUM_STREAMS];
    logic             hit;

    // Threshold register: a strobe reads the value held before its edge
    always_comb begin
        st_d = st_q;
        if (thr_we) begin
            st_d.thr = thr_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.thr <= THR_W'(THR_RESET);
        end else begin
            st_q <= st_d;
        end
    end

    assign smp_arr[STREAM_FAR]  = far_smp;
    assign smp_arr[STREAM_NEAR] = near_smp;

    for (genvar s = 0; s < NUM_STREAMS; s++) begin : g_trk
        dtd_level_track #(
            .W        (SMP_W),
            .DECAY_SH (DECAY_SH)
        ) u_trk (
            .clk       (clk),
            .rst_n     (rst_n),
            .smp_valid (smp_valid),
            .smp       (smp_arr[s]),
            .lvl_next  (lvl_nx[s]),
            .lvl       (lvl_cur[s])
        );
    end

    dtd_ratio_cmp #(
        .W  (SMP_W),
        .TW (THR_W)
    ) u_cmp (
        .far_lvl  (lvl_nx[STREAM_FAR]),
        .near_lvl (lvl_nx[STREAM_NEAR]),
        .thr      (st_q.thr),
        .hit      (hit)
    );

    dtd_hangover #(
        .HANG (HANG)
    ) u_hang (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_valid (smp_valid),
        .hit       (hit),
        .flag      (dt_flag)
    );

    assign far_lvl  = lvl_cur[STREAM_FAR];
    assign near_lvl = lvl_cur[STREAM_NEAR];
endmodule

// File: rtl/dtd_detector_chk.sv
module dtd_detector_chk #(
    parameter int SMP_W    = 16,
    parameter int DECAY_SH = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             smp_valid,
    input logic [SMP_W-1:0] far_smp,
    input logic [SMP_W-1:0] near_smp,
    input logic [SMP_W-1:0] far_lvl,
    input logic [SMP_W-1:0] near_lvl,
    input logic             dt_flag
);
    logic [SMP_W-1:0] far_mag;
    logic [SMP_W-1:0] near_mag;

    assign far_mag  = far_smp[SMP_W-1]  ? (~far_smp + 1'b1)  : far_smp;
    assign near_mag = near_smp[SMP_W-1] ? (~near_smp + 1'b1) : near_smp;

    p_reset_r1: assert property (@(posedge clk)
        !rst_n |=> (!dt_flag && far_lvl == '0 && near_lvl == '0));

    p_attack_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && far_mag > far_lvl) |=> (far_lvl == $past(far_mag)));

    p_decay_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && near_mag <= near_lvl)
        |=> (near_lvl == $past(near_lvl - (near_lvl >> DECAY_SH))));

    p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!smp_valid && rst_n) |=> ($stable(far_lvl) && $stable(near_lvl) && $stable(dt_flag)));

    p_rise_needs_near_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dt_flag) |-> (near_lvl != '0));

    p_farzero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && far_smp == '0 && far_lvl == '0 && near_mag != '0) |=> dt_flag);

    p_release_on_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dt_flag) |-> $past(smp_valid));
endmodule

bind dtd_detector dtd_detector_chk #(
    .SMP_W    (SMP_W),
    .DECAY_SH (DECAY_SH)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_valid (smp_valid),
    .far_smp   (far_smp),
    .near_smp  (near_smp),
    .far_lvl   (far_lvl),
    .near_lvl  (near_lvl),
    .dt_flag   (dt_flag)
);

// File: tb/dtd_detector_tb_top.sv
module dtd_detector_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        thr_we;
    logic [15:0] thr_wdata;
    logic        smp_valid;
    logic [15:0] far_smp;
    logic [15:0] near_smp;
    logic [15:0] far_lvl;
    logic [15:0] near_lvl;
    logic        dt_flag;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    dtd_detector dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .thr_we    (thr_we),
        .thr_wdata (thr_wdata),
        .smp_valid (smp_valid),
        .far_smp   (far_smp),
        .near_smp  (near_smp),
        .far_lvl   (far_lvl),
        .near_lvl  (near_lvl),
        .dt_flag   (dt_flag)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; thr_we = 1'b0; thr_wdata = '0;
        smp_valid = 1'b0; far_smp = '0; near_smp = '0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic strobe(input logic [15:0] f, input logic [15:0] n);
        @(negedge clk);
        smp_valid = 1'b1; far_smp = f; near_smp = n;
        @(negedge clk);
        smp_valid = 1'b0;
    endtask

    task automatic write_thr(input logic [15:0] v);
        @(negedge clk);
        thr_we = 1'b1; thr_wdata = v;
        @(negedge clk);
        thr_we = 1'b0;
    endtask

    task automatic t_reset_state();
        do_reset();
        check("R1 flag", dt_flag, 0);
        check("R1 far_lvl", far_lvl, 0);
        check("R1 near_lvl", near_lvl, 0);
    endtask

    task automatic t_tracking();
        do_reset();
        strobe(16'd1000, 16'hF830);            // near = -2000
        check("R2 far attack", far_lvl, 1000);
        check("R2 near abs attack", near_lvl, 2000);
        strobe(16'd0, 16'd0);
        check("R3 far decay 1000->985", far_lvl, 985);
        check("R3 near decay 2000->1969", near_lvl, 1969);
        strobe(16'h8000, 16'd0);               // -32768
        check("R2 most negative magnitude", far_lvl, 32768);
        do_reset();
        strobe(16'd63, 16'd0);
        strobe(16'd0, 16'd0);
        check("R3 level below step holds", far_lvl, 63);
    endtask

    task automatic t_idle();
        do_reset();
        strobe(16'd500, 16'd100);
        @(negedge clk);
        far_smp = 16'd30000; near_smp = 16'd30000;
        repeat (5) @(negedge clk);
        check("R4 far unchanged without strobe", far_lvl, 500);
        check("R4 near unchanged without strobe", near_lvl, 100);
        check("R4 flag unchanged without strobe", dt_flag, 0);
    endtask

    task automatic t_threshold_write();
        do_reset();
        write_thr(16'h2000);
        strobe(16'd10000, 16'd2500);
        check("R7 equality at 0x2000 not double talk", dt_flag, 0);
        do_reset();
        write_thr(16'h2000);
        strobe(16'd10000, 16'd2501);
        check("R7 above 0x2000 product is double talk", dt_flag, 1);
        // write in the same cycle as a strobe
        do_reset();
        @(negedge clk);
        thr_we = 1'b1; thr_wdata = 16'h2000;
        smp_valid = 1'b1; far_smp = 16'd10000; near_smp = 16'd3000;
        @(negedge clk);
        thr_we = 1'b0; smp_valid = 1'b0;
        check("R7 same-cycle write uses old threshold", dt_flag, 0);
        strobe(16'd10000, 16'd3000);           // levels 9844 / 2954, product 2461
        check("R7 new threshold at next strobe", dt_flag, 1);
    endtask

    task automatic t_default_threshold();
        do_reset();                            // also restores default after earlier writes
        strobe(16'd10000, 16'd5625);
        check("R1 R5 default 0x4800 equality no flag", dt_flag, 0);
        strobe(16'd10000, 16'd5626);
        check("R5 one above default product sets flag", dt_flag, 1);
    endtask

    task automatic t_far_zero();
        do_reset();
        strobe(16'd0, 16'd0);
        check("R6 both zero no flag", dt_flag, 0);
        strobe(16'd0, 16'd1);
        check("R6 far zero near nonzero sets flag", dt_flag, 1);
    endtask

    task automatic t_hangover();
        int bad;
        do_reset();
        strobe(16'd1000, 16'd1000);
        check("R8 flag set", dt_flag, 1);
        bad = 0;
        for (int i = 1; i <= 240; i++) begin
            strobe(16'd32767, 16'd0);
            if (dt_flag !== 1'b1) bad++;
            if (i == 100) begin
                repeat (20) @(negedge clk);
                check("R4 R8 flag held across idle gap", dt_flag, 1);
            end
        end
        check("R8 flag held for 240 strobes", bad, 0);
        strobe(16'd32767, 16'd0);
        check("R8 flag released at strobe 241", dt_flag, 0);
    endtask

    initial begin
        rst_n = 1'b0; thr_we = 1'b0; thr_wdata = '0;
        smp_valid = 1'b0; far_smp = '0; near_smp = '0;
        t_reset_state();
        t_tracking();
        t_idle();
        t_threshold_write();
        t_default_threshold();
        t_far_zero();
        t_hangover();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule